// File: doc/BRIEF.md
# BCD/Binary Clock-Calendar Counter

This block holds a time-of-day and calendar state in seven byte-wide fields: seconds, minutes, hours, day of week, date, month and year. Each strobe on the 1 Hz input moves the state forward by one second. Every carry is applied in the same cycle, from seconds up to the year. A data-format input selects plain binary or packed BCD. An hour-format input selects 0–23 counting or 12-hour counting with a PM flag. The counter works in whichever format the two inputs select when the strobe arrives.

Software loads the fields through a single-cycle write port and reads them back through an addressed, combinational read port. A freeze input holds the counter still so that all fields can be written without a carry landing between writes. When daylight-saving handling is enabled, the counter applies fixed jumps at 01:59:59 on two Sundays. In spring it jumps forward one hour. In autumn it repeats one hour, and only once that day. A one-cycle pulse marks each completed advance.

Top module: `rtc_calendar_counter`

## Requirements
- R1: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. A write stores the byte as given. The read port shows the addressed field in the same cycle. Address 7 reads as 0x00, and a write to it changes nothing.
- R2: A strobe on tick_i with set_i low advances the time by one second at that clock edge. With set_i high the strobe is ignored. A write in the same cycle as a strobe takes effect and the strobe is dropped.
- R3: upd_done_o is high for exactly the one cycle that follows each edge at which an advance was applied, and low otherwise.
- R4: With bin_mode_i = 1 the fields count in plain binary. With bin_mode_i = 0 they count in packed BCD, with tens in bits 7:4 and units in bits 3:0. For example, seconds 0x09 becomes 0x0A in binary and 0x10 in BCD.
- R5: Seconds and minutes wrap from 59 to 0 and carry to the next field. Hours carry into the date at the end of the day. The year runs 0 to 99 and wraps to 0. The day of week runs 1 to 7, where 1 is Sunday, and advances at every date rollover.
- R6: Months have 30 or 31 days as usual. February has 29 days when year mod 4 = 0 and 28 days otherwise. The date wraps to 1 and carries into the month, and the month wraps from 12 to 1.
- R7: With hour24_i = 1, hours run 0 to 23. With hour24_i = 0, bit 7 of the hours byte is the PM flag and bits 6:0 hold 12, 1 … 11. The flag toggles when the time passes 11:59:59 to 12:00:00.
- R8: With dst_en_i = 1, on a Sunday with date 1 to 7 in month 4, the time steps from 01:59:59 (AM) straight to 03:00:00.
- R9: With dst_en_i = 1, on the last Sunday of month 10 (date + 7 > 31), the first advance from 01:59:59 goes to 01:00:00. Later passes through 01:59:59 that day advance normally, even if the fields are rewritten. The once-only mark is cleared at the next date rollover.
- R10: With dst_en_i = 0, or on any other day, 01:59:59 advances normally to 02:00:00.
- R11: After reset the fields read 00:00:00, day 1, date 1, month 1, year 0, and upd_done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| set_i | input | 1 | Freeze: ignore strobes while high |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = BCD fields |
| hour24_i | input | 1 | 1 = 24-hour counting, 0 = 12-hour with PM flag |
| dst_en_i | input | 1 | Enable the daylight-saving jumps |
| wr_en_i | input | 1 | Field write strobe |
| addr_i | input | 3 | Field address for both read and write |
| wr_data_i | input | 8 | Field write data |
| rd_data_o | output | 8 | Addressed field, combinational |
| upd_done_o | output | 1 | One-cycle pulse after each applied advance |

## Verification
A write or a strobe sampled at one rising edge changes the fields at that same edge, and upd_done_o goes high during the following cycle. The read port has no register of its own, so the new value can be seen as soon as the address is applied. The bench drives every input on the falling edge and lets exactly one rising edge pass. It then checks upd_done_o on the next falling edge and sets the read address, waiting a short delay before comparing the read data. The pulse width is checked by sampling again one falling edge later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W  = 8;
  localparam int N_FIELDS = 7;
  localparam int ADDR_W   = $clog2(N_FIELDS + 1);

  typedef logic [FIELD_W-1:0] fld_t;

  typedef enum logic [ADDR_W-1:0] {
    F_SEC   = 3'd0,
    F_MIN   = 3'd1,
    F_HOUR  = 3'd2,
    F_DOW   = 3'd3,
    F_DATE  = 3'd4,
    F_MONTH = 3'd5,
    F_YEAR  = 3'd6
  } field_e;

  // stored byte -> binary value
  function automatic fld_t dec(input fld_t v, input logic bin);
    fld_t tens;
    tens = {4'd0, v[7:4]} * 8'd10;
    return bin ? v : (tens + {4'd0, v[3:0]});
  endfunction

  // binary value -> stored byte
  function automatic fld_t enc(input fld_t v, input logic bin);
    fld_t t, o;
    t = v / 8'd10;
    o = v % 8'd10;
    return bin ? v : {t[3:0], o[3:0]};
  endfunction

  function automatic fld_t days_in(input fld_t month, input fld_t year);
    case (month)
      8'd2:                    return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_date_next.sv
module rtc_date_next
  import rtc_pkg::*;
#(
  parameter int SPRING_MONTH = 4,
  parameter int FALL_MONTH   = 10
) (
  input  fld_t dow_i,
  input  fld_t date_i,
  input  fld_t month_i,
  input  fld_t year_i,
  input  logic bin_i,
  input  logic carry_i,
  output fld_t dow_o,
  output fld_t date_o,
  output fld_t month_o,
  output fld_t year_o,
  output logic spring_day_o,
  output logic fall_day_o
);
  localparam fld_t SPRING_M = fld_t'(SPRING_MONTH);
  localparam fld_t FALL_M   = fld_t'(FALL_MONTH);

  fld_t w, d, mo, y, dim;
  fld_t wn, dn, mon, yn;
  logic c_date, c_month;

  always_comb begin
    w   = dec(dow_i, bin_i);
    d   = dec(date_i, bin_i);
    mo  = dec(month_i, bin_i);
    y   = dec(year_i, bin_i);
    dim = days_in(mo, y);

    spring_day_o = (mo == SPRING_M) && (w == 8'd1) && (d <= 8'd7);
    fall_day_o   = (mo == FALL_M) && (w == 8'd1) && ((d + 8'd7) > dim);

    c_date  = carry_i && (d >= dim);
    c_month = c_date && (mo >= 8'd12);

    wn  = carry_i ? ((w >= 8'd7) ? 8'd1 : w + 8'd1) : w;
    dn  = carry_i ? (c_date ? 8'd1 : d + 8'd1) : d;
    mon = c_date ? (c_month ? 8'd1 : mo + 8'd1) : mo;
    yn  = c_month ? ((y >= 8'd99) ? 8'd0 : y + 8'd1) : y;

    dow_o   = enc(wn, bin_i);
    date_o  = enc(dn, bin_i);
    month_o = enc(mon, bin_i);
    year_o  = enc(yn, bin_i);
  end
endmodule

// File: rtl/rtc_time_next.sv
module rtc_time_next
  import rtc_pkg::*;
(
  input  fld_t sec_i,
  input  fld_t min_i,
  input  fld_t hour_i,
  input  logic bin_i,
  input  logic h24_i,
  input  logic dst_en_i,
  input  logic spring_day_i,
  input  logic fall_day_i,
  input  logic fall_done_i,
  output fld_t sec_o,
  output fld_t min_o,
  output fld_t hour_o,
  output logic day_carry_o,
  output logic fall_hit_o
);
  fld_t s, m, h, h12, sn, mn, hn, h12n, hraw;
  logic c_sec, c_min, at_jump, spring_hit;

  always_comb begin
    s   = dec(sec_i, bin_i);
    m   = dec(min_i, bin_i);
    h12 = dec({1'b0, hour_i[6:0]}, bin_i);
    if (h24_i) h = dec(hour_i, bin_i);
    else       h = ((h12 >= 8'd12) ? 8'd0 : h12) + (hour_i[7] ? 8'd12 : 8'd0);

    at_jump    = dst_en_i && (h == 8'd1) && (m == 8'd59) && (s == 8'd59);
    spring_hit = at_jump && spring_day_i;
    fall_hit_o = at_jump && fall_day_i && !fall_done_i;

    c_sec = (s >= 8'd59);
    c_min = c_sec && (m >= 8'd59);
    day_carry_o = 1'b0;

    if (spring_hit) begin
      sn = 8'd0; mn = 8'd0; hn = 8'd3;
    end else if (fall_hit_o) begin
      sn = 8'd0; mn = 8'd0; hn = 8'd1;
    end else begin
      sn = c_sec ? 8'd0 : s + 8'd1;
      mn = c_sec ? (c_min ? 8'd0 : m + 8'd1) : m;
      hn = c_min ? ((h >= 8'd23) ? 8'd0 : h + 8'd1) : h;
      day_carry_o = c_min && (h >= 8'd23);
    end

    h12n = hn % 8'd12;
    if (h12n == 8'd0) h12n = 8'd12;
    hraw = enc(h12n, bin_i);

    sec_o  = enc(sn, bin_i);
    min_o  = enc(mn, bin_i);
    hour_o = h24_i ? enc(hn, bin_i) : {(hn >= 8'd12), hraw[6:0]};
  end
endmodule

// File: rtl/rtc_calendar_counter.sv
module rtc_calendar_counter
  import rtc_pkg::*;
#(
  parameter int SPRING_MONTH = 4,
  parameter int FALL_MONTH   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              set_i,
  input  logic              bin_mode_i,
  input  logic              hour24_i,
  input  logic              dst_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  output logic [FIELD_W-1:0] rd_data_o,
  output logic              upd_done_o
);
  fld_t field_q [N_FIELDS];
  fld_t nxt     [N_FIELDS];
  logic fall_done_q, upd_q;
  logic adv, day_carry, fall_hit, spring_day, fall_day;

  assign adv = tick_i && !set_i && !wr_en_i;

  rtc_time_next u_time (
    .sec_i       (field_q[F_SEC]),
    .min_i       (field_q[F_MIN]),
    .hour_i      (field_q[F_HOUR]),
    .bin_i       (bin_mode_i),
    .h24_i       (hour24_i),
    .dst_en_i    (dst_en_i),
    .spring_day_i(spring_day),
    .fall_day_i  (fall_day),
    .fall_done_i (fall_done_q),
    .sec_o       (nxt[F_SEC]),
    .min_o       (nxt[F_MIN]),
    .hour_o      (nxt[F_HOUR]),
    .day_carry_o (day_carry),
    .fall_hit_o  (fall_hit)
  );

  rtc_date_next #(
    .SPRING_MONTH(SPRING_MONTH),
    .FALL_MONTH  (FALL_MONTH)
  ) u_date (
    .dow_i       (field_q[F_DOW]),
    .date_i      (field_q[F_DATE]),
    .month_i     (field_q[F_MONTH]),
    .year_i      (field_q[F_YEAR]),
    .bin_i       (bin_mode_i),
    .carry_i     (day_carry),
    .dow_o       (nxt[F_DOW]),
    .date_o      (nxt[F_DATE]),
    .month_o     (nxt[F_MONTH]),
    .year_o      (nxt[F_YEAR]),
    .spring_day_o(spring_day),
    .fall_day_o  (fall_day)
  );

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    localparam fld_t RST_VAL = (i == F_DOW || i == F_DATE || i == F_MONTH) ? 8'd1 : 8'd0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   field_q[i] <= RST_VAL;
      else if (wr_en_i && addr_i == ADDR_W'(i))      field_q[i] <= wr_data_i;
      else if (adv)                                  field_q[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_done_q <= 1'b0;
      upd_q       <= 1'b0;
    end else begin
      upd_q <= adv;
      if (adv && fall_hit)       fall_done_q <= 1'b1;
      else if (adv && day_carry) fall_done_q <= 1'b0;
    end
  end

  assign upd_done_o = upd_q;
  assign rd_data_o  = (addr_i < ADDR_W'(N_FIELDS)) ? field_q[addr_i[ADDR_W-1:0]] : '0;

  // R1: written byte lands in the addressed field
  a_r1_write_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == F_SEC |=> field_q[F_SEC] == $past(wr_data_i));

  // R2: frozen counter holds its seconds
  a_r2_set_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !wr_en_i |=> $stable(field_q[F_SEC]));

  // R3: pulse follows an accepted strobe, and only then
  a_r3_pulse_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !set_i && !wr_en_i |=> upd_done_o);
  a_r3_pulse_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !upd_done_o);

  // R4: binary seconds stay in range after an advance
  a_r4_bin_sec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o && bin_mode_i && $past(bin_mode_i) |-> field_q[F_SEC] < 8'd60);

  // R5: day of week in 1..7 after an advance
  a_r5_dow_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o && bin_mode_i == $past(bin_mode_i) |-> field_q[F_DOW] >= 8'd1 && field_q[F_DOW] <= 8'd7);

  // R7: binary 24-hour hours stay below 24 after an advance
  a_r7_hour24_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o && hour24_i && bin_mode_i && $past(hour24_i) && $past(bin_mode_i)
    |-> field_q[F_HOUR] < 8'd24);

  // R9: the fall-back mark only sets on an October Sunday
  a_r9_mark_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fall_done_q) |-> $past(dst_en_i) && $past(fall_day));
endmodule

// File: tb/rtc_calendar_counter_test.sv
module rtc_calendar_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, set = 1'b0, bin = 1'b0, h24 = 1'b1, dst = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       upd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .set_i(set),
    .bin_mode_i(bin), .hour24_i(h24), .dst_en_i(dst),
    .wr_en_i(wr), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .upd_done_o(upd)
  );

  // {bin,h24,dst, start sec..year, expected sec..year}
  localparam int NV = 17;
  localparam logic [114:0] VEC [NV] = '{
    {3'b010, 56'h56_34_12_04_15_06_23, 56'h57_34_12_04_15_06_23},
    {3'b010, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00},
    {3'b010, 56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},
    {3'b010, 56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23},
    {3'b010, 56'h59_59_23_04_29_02_24, 56'h00_00_00_05_01_03_24},
    {3'b110, 56'h3B_3B_17_05_1E_04_15, 56'h00_00_00_06_01_05_15},
    {3'b110, 56'h09_10_05_01_01_01_00, 56'h0A_10_05_01_01_01_00},
    {3'b010, 56'h09_10_05_01_01_01_00, 56'h10_10_05_01_01_01_00},
    {3'b000, 56'h59_59_11_05_10_03_22, 56'h00_00_92_05_10_03_22},
    {3'b000, 56'h59_59_92_05_10_03_22, 56'h00_00_81_05_10_03_22},
    {3'b000, 56'h59_59_91_05_10_03_22, 56'h00_00_12_06_11_03_22},
    {3'b100, 56'h3B_3B_0C_05_0A_03_16, 56'h00_00_01_05_0A_03_16},
    {3'b011, 56'h59_59_01_01_05_04_25, 56'h00_00_03_01_05_04_25},
    {3'b011, 56'h59_59_01_01_12_04_25, 56'h00_00_02_01_12_04_25},
    {3'b010, 56'h59_59_01_01_05_04_25, 56'h00_00_02_01_05_04_25},
    {3'b001, 56'h59_59_01_01_05_04_25, 56'h00_00_03_01_05_04_25},
    {3'b011, 56'h59_59_01_01_18_10_25, 56'h00_00_02_01_18_10_25}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:        return "R5";
      2, 3, 4:     return "R6";
      5, 6, 7:     return "R4";
      8, 9, 10, 11: return "R7";
      12, 15:      return "R8";
      default:     return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_fld(int a, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic load(logic [55:0] f);
    for (int i = 0; i < 7; i++) wr_fld(i, f[55-8*i -: 8]);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, logic [7:0] exp);
    addr = 3'(a);
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    logic [114:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 upd", {7'd0, upd}, 8'h00);
    rd_chk("R11 sec", 0, 8'h00);
    rd_chk("R11 min", 1, 8'h00);
    rd_chk("R11 hour", 2, 8'h00);
    rd_chk("R11 dow", 3, 8'h01);
    rd_chk("R11 date", 4, 8'h01);
    rd_chk("R11 month", 5, 8'h01);
    rd_chk("R11 year", 6, 8'h00);

    // table walk
    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      bin = e[114]; h24 = e[113]; dst = e[112];
      load(e[111:56]);
      do_tick();
      chk({vtag(v), " R2 R3 pulse"}, {7'd0, upd}, 8'h01);
      for (int i = 0; i < 7; i++)
        rd_chk($sformatf("%s vec %0d field %0d", vtag(v), v, i), i, e[55-8*i -: 8]);
    end

    bin = 1'b0; h24 = 1'b1; dst = 1'b0;

    // R1 write/read and unused address
    wr_fld(1, 8'h42);
    rd_chk("R1 min write", 1, 8'h42);
    wr_fld(7, 8'h55);
    rd_chk("R1 addr7 read", 7, 8'h00);
    rd_chk("R1 addr7 no side effect", 0, 8'h00);

    // R3 pulse width
    do_tick();
    chk("R3 pulse high", {7'd0, upd}, 8'h01);
    @(negedge clk);
    chk("R3 pulse one cycle", {7'd0, upd}, 8'h00);
    rd_chk("R2 advanced", 0, 8'h01);

    // R2 freeze
    set = 1'b1;
    wr_fld(0, 8'h30);
    do_tick();
    chk("R2 freeze no pulse", {7'd0, upd}, 8'h00);
    rd_chk("R2 freeze sec", 0, 8'h30);
    set = 1'b0;

    // R2 write in the tick cycle drops the tick
    @(negedge clk);
    wr = 1'b1; addr = 3'd0; wdata = 8'h20; tick = 1'b1;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    chk("R2 write wins pulse", {7'd0, upd}, 8'h00);
    rd_chk("R2 write wins sec", 0, 8'h20);

    // R9 fall back once
    dst = 1'b1;
    load(56'h59_59_01_01_26_10_25);
    do_tick();
    rd_chk("R9 fall hour", 2, 8'h01);
    rd_chk("R9 fall min", 1, 8'h00);
    rd_chk("R9 fall sec", 0, 8'h00);
    wr_fld(0, 8'h59);
    wr_fld(1, 8'h59);
    do_tick();
    rd_chk("R9 second pass normal", 2, 8'h02);
    wr_fld(0, 8'h59);
    wr_fld(1, 8'h59);
    wr_fld(2, 8'h23);
    do_tick();
    rd_chk("R9 midnight date", 4, 8'h27);
    rd_chk("R9 midnight dow", 3, 8'h02);
    load(56'h59_59_01_01_26_10_25);
    do_tick();
    rd_chk("R9 mark cleared", 2, 8'h01);
    dst = 1'b0;

    done = 1'b1;
    report();
  end
endmodule